// File: doc/BRIEF.md
# Dual-Channel Timer/Counter

Two independent 16-bit count channels sit behind a small register port. Each channel takes its configuration from its own half of a shared configuration byte. In timer mode a channel advances on a machine tick, which the block makes by dividing the clock by a fixed ratio. In counter mode it advances once for each falling transition seen on its external count pin. A run bit in the control byte starts each channel. A gate option can also make counting depend on a second external pin being high.

Three count shapes are supported: a 13-bit count with a 5-bit prescaler, a full 16-bit count, and an 8-bit low byte that reloads itself from the high byte. The fourth mode code freezes the channel. When a channel wraps, it sets its overflow flag in the control byte, and that flag stays set until software writes it to zero. It also drives a one-cycle pulse on a dedicated output, which serial baud logic and interrupt logic can use. The block has no streaming data path. All of its pins are plain register-access or control/status pins.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0x00, and both `ovf_pulse` bits and both `ovf_flag` bits are low.
- R2: Register addresses are: 0 configuration, 1 control, 2 channel-0 low byte, 3 channel-0 high byte, 4 channel-1 low byte, 5 channel-1 high byte. Reads are combinational. A write takes effect at the clock edge where `reg_wr` is sampled high. Configuration bits 3..0 belong to channel 0 and bits 7..4 to channel 1. Within each nibble, from MSB to LSB, the bits are gate-enable, external-count select and a 2-bit mode. Control bits 7..4 are overflow-1, run-1, overflow-0, run-0. Control bits 3..0 are plain read/write storage.
- R3: In mode 01 the high and low bytes form one 16-bit count. The step from 0xFFFF goes to 0x0000 and sets the channel's overflow flag.
- R4: With external-count select at 0, a channel steps once every `TICK_DIV` (default 12) clocks.
- R5: In mode 10, a step from low byte 0xFF loads the low byte with the high byte and sets the overflow flag. The high byte is unchanged.
- R6: In mode 00, the 13-bit value {high byte, low byte bits 4..0} counts. Low byte bits 7..5 are kept as they are. The step from 0x1FFF goes to zero and sets the overflow flag.
- R7: With external-count select at 1, the channel steps exactly once when two consecutive tick samples of its count pin read high and then low.
- R8: With gate-enable at 1, the channel holds its count while its gate pin is low.
- R9: With the channel's run bit at 0, its count holds.
- R10: In mode 11, the channel holds its count and raises neither its pulse nor its flag.
- R11: Writing 0 to an overflow bit clears it. If a hardware overflow lands in the same cycle as that write, the flag ends up set.
- R12: `ovf_pulse[i]` is high for exactly one cycle per overflow. It appears in the same cycle that `ovf_flag[i]` first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_cnt_pin | input | 2 | External count input per channel |
| gate_pin | input | 2 | Count gate input per channel |
| ovf_pulse | output | 2 | One-cycle overflow pulse per channel |
| ovf_flag | output | 2 | Overflow flag per channel |

## Verification
Reads return the register value in the same cycle, and a write shows up from the next cycle on.

A step happens only on a machine tick, and the tick phase is not visible at the ports. The bench therefore never samples at an absolute offset from a write. It measures the interval between two overflow pulses, which must be exactly 16 × 12 clocks for a 16-step reload. It also reads counts within two cycles of a pulse, well before the next tick.

The overflow flag and the pulse both appear one cycle after the wrapping edge. They are checked at the falling edge where the pulse is first seen.

External pins pass through two synchronizer stages and then wait for a tick. For that reason the bench holds every pin level for 30 clocks before it expects a count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRESC  = 2'b00,
    MODE_WIDE   = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_HOLD   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      ext_sel;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W  = 8,
  parameter int PS = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  chan_cfg_t    cfg,
  input  logic         run,
  input  logic         gate_in,
  input  logic         ext_in,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_set,
  output logic         ovf_pulse
);
  localparam int PW = W + PS;

  logic         samp_q;
  logic         fall;
  logic         step;
  logic         wrap;
  logic [W-1:0] lo_n, hi_n;
  logic [PW-1:0] p13;
  logic [2*W-1:0] p16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp_q <= 1'b0;
    else if (tick) samp_q <= ext_in;
  end

  assign fall = tick & samp_q & ~ext_in;
  assign step = run & (~cfg.gate_en | gate_in) & (cfg.ext_sel ? fall : tick)
              & ~wr_lo & ~wr_hi;
  assign p13  = {hi, lo[PS-1:0]} + 1'b1;
  assign p16  = {hi, lo} + 1'b1;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    unique case (cfg.mode)
      MODE_PRESC: begin
        wrap = &{hi, lo[PS-1:0]};
        lo_n = {lo[W-1:PS], p13[PS-1:0]};
        hi_n = p13[PW-1:PS];
      end
      MODE_WIDE: begin
        wrap = &{hi, lo};
        {hi_n, lo_n} = p16;
      end
      MODE_RELOAD: begin
        wrap = &lo;
        lo_n = wrap ? hi : lo + 1'b1;
      end
      default: ;
    endcase
  end

  assign ovf_set = step & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo        <= '0;
      hi        <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_set;
      if (wr_lo) lo <= wdata;
      if (wr_hi) hi <= wdata;
      if (step) begin
        lo <= lo_n;
        hi <= hi_n;
      end
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int NCH      = 2,
  parameter int W        = 8,
  parameter int PS       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [NCH-1:0]    ext_cnt_pin,
  input  logic [NCH-1:0]    gate_pin,
  output logic [NCH-1:0]    ovf_pulse,
  output logic [NCH-1:0]    ovf_flag
);
  localparam int AUXW = W - 2 * NCH;

  logic                  tick;
  logic [NCH-1:0]        ext_s, gate_s;
  chan_cfg_t [NCH-1:0]   mode_q;
  logic [NCH-1:0]        tf_q, tr_q;
  logic [AUXW-1:0]       aux_q;
  logic [NCH-1:0][W-1:0] cnt_lo, cnt_hi;
  logic [NCH-1:0]        ovf_set;
  logic                  ctrl_wr;

  tmr_tick_gen #(.DIV(TICK_DIV)) tick_i (.clk(clk), .rst_n(rst_n), .tick(tick));

  tmr_sync #(.N(2 * NCH)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({gate_pin, ext_cnt_pin}),
    .q({gate_s, ext_s})
  );

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tf_q   <= '0;
      tr_q   <= '0;
      aux_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CFG) mode_q <= reg_wdata;
      if (ctrl_wr) begin
        aux_q <= reg_wdata[AUXW-1:0];
        for (int i = 0; i < NCH; i++) begin
          tr_q[i] <= reg_wdata[AUXW + 2*i];
          tf_q[i] <= reg_wdata[AUXW + 2*i + 1];
        end
      end
      for (int i = 0; i < NCH; i++)
        if (ovf_set[i]) tf_q[i] <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam logic [ADDR_W-1:0] LO_A = ADDR_LO0 + ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] HI_A = LO_A + 1'b1;

    tmr_chan #(.W(W), .PS(PS)) chan_i (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cfg(mode_q[i]), .run(tr_q[i]),
      .gate_in(gate_s[i]), .ext_in(ext_s[i]),
      .wr_lo(reg_wr && reg_addr == LO_A),
      .wr_hi(reg_wr && reg_addr == HI_A),
      .wdata(reg_wdata),
      .lo(cnt_lo[i]), .hi(cnt_hi[i]),
      .ovf_set(ovf_set[i]), .ovf_pulse(ovf_pulse[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CFG)       reg_rdata = mode_q;
    else if (reg_addr == ADDR_CTRL) begin
      reg_rdata[AUXW-1:0] = aux_q;
      for (int i = 0; i < NCH; i++) begin
        reg_rdata[AUXW + 2*i]     = tr_q[i];
        reg_rdata[AUXW + 2*i + 1] = tf_q[i];
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == ADDR_LO0 + ADDR_W'(2 * i))     reg_rdata = cnt_lo[i];
        if (reg_addr == ADDR_LO0 + ADDR_W'(2 * i + 1)) reg_rdata = cnt_hi[i];
      end
    end
  end

  assign ovf_flag = tf_q;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input chan_cfg_t [NCH-1:0]   mode_q,
  input logic [NCH-1:0]        tr_q,
  input logic [NCH-1:0][W-1:0] cnt_lo,
  input logic [NCH-1:0][W-1:0] cnt_hi,
  input logic [NCH-1:0]        ovf_pulse,
  input logic [NCH-1:0]        ovf_flag
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_pulse_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[i] |-> ovf_flag[i]);
    assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[i] |=> !ovf_pulse[i]);
    assert_hold_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i].mode == MODE_HOLD && !reg_wr) |=>
        ($stable(cnt_lo[i]) && $stable(cnt_hi[i]) && !ovf_pulse[i]));
    assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tr_q[i] && !reg_wr) |=> ($stable(cnt_lo[i]) && $stable(cnt_hi[i])));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse[i] && $past(mode_q[i].mode) == MODE_RELOAD && !$past(reg_wr))
        |-> (cnt_lo[i] == cnt_hi[i]));
    assert_wide_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse[i] && $past(mode_q[i].mode) == MODE_WIDE && !$past(reg_wr))
        |-> (cnt_lo[i] == '0 && cnt_hi[i] == '0));
  end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mode_q(mode_q), .tr_q(tr_q),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
);

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ext_cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ovf_pulse, ovf_flag;

  always #5 clk = ~clk;

  tmr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt_pin(ext_cnt_pin),
    .gate_pin(gate_pin), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t mon_item;
  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  int pulse_cnt0 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results and compares them mid-cycle
  always @(negedge clk) begin
    if (ovf_pulse[0]) pulse_cnt0++;
    if (sb_q.size() > 0) begin
      mon_item = sb_q.pop_front();
      chk(reg_rdata == mon_item.exp, mon_item.tag, reg_rdata, mon_item.exp);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // Driver: pushes the expected value, monitor compares it
  task automatic sb_read(input logic [2:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_pulse(input int ch, input int limit, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < limit && !seen; k++) begin
      @(negedge clk);
      if (ovf_pulse[ch]) seen = 1'b1;
    end
  endtask

  task automatic ext_pulse(input int ch);
    @(posedge clk); #1;
    ext_cnt_pin[ch] = 1'b0;
    wait_clks(30);
    ext_cnt_pin[ch] = 1'b1;
    wait_clks(30);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit seen;
    bit seen2;
    longint t1;
    logic [7:0] v, v2;

    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) sb_read(3'(a), 8'h00, "R1 reset register");
    chk(ovf_pulse == 2'b00 && ovf_flag == 2'b00, "R1 reset outputs",
        {ovf_pulse, ovf_flag}, 0);

    // R2 control storage bits and field layout
    reg_write(3'd1, 8'h0F);
    sb_read(3'd1, 8'h0F, "R2 control low bits");
    reg_write(3'd0, 8'hA5);
    sb_read(3'd0, 8'hA5, "R2 configuration readback");
    reg_write(3'd1, 8'h00);

    // R3 16-bit wrap on channel 0 (cfg nibble 0001)
    reg_write(3'd0, 8'h01);
    reg_write(3'd2, 8'hFD);
    reg_write(3'd3, 8'hFF);
    reg_write(3'd1, 8'h10);
    wait_pulse(0, 100, seen);
    chk(seen, "R3 wide overflow pulse", seen, 1);
    chk(ovf_flag[0], "R12 flag with pulse", ovf_flag[0], 1);
    sb_read(3'd2, 8'h00, "R3 low byte after wrap");
    sb_read(3'd3, 8'h00, "R3 high byte after wrap");
    sb_read(3'd1, 8'h30, "R2 control shows overflow-0 and run-0");
    reg_write(3'd1, 8'h00);
    sb_read(3'd1, 8'h00, "R11 software clear of overflow");

    // R4/R5 reload on channel 1 (cfg nibble 0010), interval 16 ticks * 12
    reg_write(3'd0, 8'h20);
    reg_write(3'd5, 8'hF0);
    reg_write(3'd4, 8'hF0);
    reg_write(3'd1, 8'h40);
    wait_pulse(1, 400, seen);
    t1 = cyc;
    wait_pulse(1, 400, seen2);
    chk(seen && seen2 && (cyc - t1) == 192, "R4 tick period between reloads",
        int'(cyc - t1), 192);
    sb_read(3'd4, 8'hF0, "R5 low byte reloaded");
    sb_read(3'd5, 8'hF0, "R5 high byte kept");
    reg_write(3'd1, 8'h00);

    // R7 external falling edges on channel 0 (cfg nibble 0101)
    reg_write(3'd0, 8'h05);
    reg_write(3'd2, 8'h00);
    reg_write(3'd3, 8'h00);
    reg_write(3'd1, 8'h10);
    for (int k = 0; k < 5; k++) ext_pulse(0);
    sb_read(3'd2, 8'h05, "R7 five edges counted");
    sb_read(3'd3, 8'h00, "R7 high byte");

    // R8 gate on channel 0 (cfg nibble 1001)
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h09);
    reg_write(3'd2, 8'h00);
    reg_write(3'd1, 8'h10);
    wait_clks(100);
    sb_read(3'd2, 8'h00, "R8 gate low holds");
    gate_pin[0] = 1'b1;
    wait_clks(120);
    peek(3'd2, v);
    chk(v >= 8'd9 && v <= 8'd10, "R8 gate high counts", v, 10);
    gate_pin[0] = 1'b0;
    wait_clks(5);
    peek(3'd2, v);
    wait_clks(60);
    sb_read(3'd2, v, "R8 gate low again holds");

    // R9 run bit clear holds
    reg_write(3'd0, 8'h01);
    reg_write(3'd1, 8'h00);
    peek(3'd2, v);
    wait_clks(60);
    sb_read(3'd2, v, "R9 stopped channel holds");

    // R6 13-bit mode on channel 1 via external pin (cfg nibble 0100)
    reg_write(3'd0, 8'h40);
    reg_write(3'd4, 8'hFE);
    reg_write(3'd5, 8'hFF);
    reg_write(3'd1, 8'h40);
    ext_pulse(1);
    sb_read(3'd4, 8'hFF, "R6 prescaler step");
    chk(!ovf_flag[1], "R6 no flag before wrap", ovf_flag[1], 0);
    ext_pulse(1);
    chk(ovf_flag[1], "R6 flag on 13-bit wrap", ovf_flag[1], 1);
    sb_read(3'd4, 8'hE0, "R6 low byte upper bits kept");
    sb_read(3'd5, 8'h00, "R6 high byte wrapped");

    // R10 mode 11 freezes channel 0
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h03);
    reg_write(3'd2, 8'h12);
    reg_write(3'd3, 8'h34);
    pulse_cnt0 = 0;
    reg_write(3'd1, 8'h10);
    wait_clks(100);
    sb_read(3'd2, 8'h12, "R10 low byte frozen");
    sb_read(3'd3, 8'h34, "R10 high byte frozen");
    chk(pulse_cnt0 == 0 && !ovf_flag[0], "R10 no overflow", pulse_cnt0, 0);

    // R11 hardware set beats a same-cycle software clear (channel 1 wide)
    reg_write(3'd1, 8'h00);
    reg_write(3'd0, 8'h10);
    reg_write(3'd4, 8'hFF);
    reg_write(3'd5, 8'hFF);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h40;
    seen = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (ovf_pulse[1]) begin
        seen = 1'b1;
        chk(ovf_flag[1], "R11 flag survives clearing write", ovf_flag[1], 1);
      end
    end
    @(posedge clk); #1;
    reg_wr = 1'b0;
    chk(seen, "R12 pulse during clearing writes", seen, 1);

    wait_clks(3);
    finish_run();
  end
endmodule